// File: doc/BRIEF.md
# Immediate-Operand Instruction Bus Slot Sequencer

This block is the timing sequencer for a processor executing a logic or arithmetic instruction that carries an immediate operand. After one start strobe it steps through a fixed list of slots. Each slot is a program read, a data read, a data write, a short internal idle or a full internal idle. The list depends on the operand size and on the kind of destination: a data register, one of seven memory addressing modes, or the status/condition register. The block reports the current slot on every clock. For long operands it also flags whether the current data access targets the high or the low word. It pulses done once the last slot has finished.

Bus slots wait on a ready handshake from the memory side, so wait states stretch the sequence. Internal idle slots always run for their fixed length. The status-register destination follows its own longer order, with two idle slots and a refill of the prefetch, because a mode change must settle before new program words are fetched. Address arithmetic, the ALU and the prefetch storage belong to neighbouring blocks, which use the slot code to decide what to do on each clock.

Top module: `immSlotSequencer`

## Requirements
- R1: After reset, slotKind is 0 (no slot), hiWord is 0 and done is 0. The slotKind codes are: 0 none, 1 program read, 2 data read, 3 data write, 4 short idle (2 clocks), 5 full idle (4 clocks).
- R2: A start seen while the block is idle latches sizeLong and destKind. The first slot appears in the clock after the one in which start was sampled. The destKind codes are: 0 data register, 1 indirect, 2 post-increment, 3 pre-decrement, 4 displacement, 5 indexed, 6 absolute word, 7 absolute long, 8 to 15 status/condition register.
- R3: For a byte/word operand and destKind 0, the order is program read, program read (8 clocks with no wait states).
- R4: For a long operand and destKind 0, the order is three program reads and then one full idle (16 clocks).
- R5: For a byte/word operand and a memory destination, the order is program read, address-extension slots, data read, program read, data write. Codes 1 and 2 have no extension slots and take 16 clocks.
- R6: The extension slots are: code 3 one short idle, code 4 one program read, code 5 a short idle and then a program read, code 6 one program read, code 7 two program reads. With no waits, byte/word totals are 18, 20, 22, 20 and 24 clocks, and long totals are 30, 32, 34, 32 and 36 clocks.
- R7: For a long operand and a memory destination, the order is two program reads, the extension slots, a data read of the high word (hiWord 1), a data read of the low word (hiWord 0), a program read, a data write of the low word (hiWord 0) and a data write of the high word (hiWord 1). hiWord is 0 in every other slot. Codes 1 and 2 take 28 clocks.
- R8: For destKind 8 to 15, the order is program read, full idle, full idle, program read, program read (20 clocks), whatever the value of sizeLong.
- R9: A bus slot (codes 1 to 3) lasts 4 clocks when busReady is high. While busReady is low in its last clock, the slot repeats that clock.
- R10: Idle slots (codes 4 and 5) keep their fixed length whatever the value of busReady.
- R11: done is high for exactly one clock, in the clock after the final slot. slotKind is 0 in that clock.
- R12: A start that arrives while a sequence or its done clock is in progress has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sequence when the block is idle |
| sizeLong | input | 1 | 1 = long operand, 0 = byte or word |
| destKind | input | 4 | Destination kind code |
| busReady | input | 1 | Memory side ready; ends a bus slot in its last clock |
| slotKind | output | 3 | Code of the slot in the current clock |
| hiWord | output | 1 | The current data access targets the high word |
| done | output | 1 | One-clock pulse after the final slot |

## Verification
The first slot code is due one clock after the edge that samples start. After that, each slot code holds for its length plus any stalled clocks, and done rises in the clock after the last slot's final clock. The bench keeps a reference that steps slot by slot and clock by clock, built from the ordering rules above. It drives inputs and samples outputs on the falling edge, so each comparison looks at the state the last rising edge produced. It also checks the number of active clocks per sequence against the listed totals, plus any stall clocks it injected.

// File: rtl/immSeqPkg.sv
package immSeqPkg;

  localparam int MAX_SLOTS       = 10;
  localparam int IDX_W           = $clog2(MAX_SLOTS + 1);
  localparam int BUS_CLKS        = 4;
  localparam int IDLE_FULL_CLKS  = 4;
  localparam int IDLE_SHORT_CLKS = 2;
  localparam int MAX_LEN         = 4;
  localparam int CNT_W           = $clog2(MAX_LEN);
  localparam int DK_W            = 4;

  localparam logic [DK_W-1:0] DK_DREG    = 4'd0;
  localparam logic [DK_W-1:0] DK_IND     = 4'd1;
  localparam logic [DK_W-1:0] DK_POSTINC = 4'd2;
  localparam logic [DK_W-1:0] DK_PREDEC  = 4'd3;
  localparam logic [DK_W-1:0] DK_DISP    = 4'd4;
  localparam logic [DK_W-1:0] DK_INDEX   = 4'd5;
  localparam logic [DK_W-1:0] DK_ABSW    = 4'd6;
  localparam logic [DK_W-1:0] DK_ABSL    = 4'd7;

  typedef enum logic [2:0] {
    SK_NONE   = 3'd0,
    SK_PROG   = 3'd1,
    SK_DRD    = 3'd2,
    SK_DWR    = 3'd3,
    SK_IDLE_S = 3'd4,
    SK_IDLE_F = 3'd5
  } slotKind_e;

  typedef struct packed {
    slotKind_e kind;
    logic      hi;
  } slot_t;

  typedef struct packed {
    slot_t [MAX_SLOTS-1:0] slots;
    logic  [IDX_W-1:0]     len;
  } plan_t;

  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic clrCnt;
    logic incCnt;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seqState_e;

  function automatic logic isBusSlot(slotKind_e k);
    return (k == SK_PROG) || (k == SK_DRD) || (k == SK_DWR);
  endfunction

  function automatic logic [CNT_W-1:0] slotLastCnt(slotKind_e k);
    case (k)
      SK_IDLE_S: return CNT_W'(IDLE_SHORT_CLKS - 1);
      SK_IDLE_F: return CNT_W'(IDLE_FULL_CLKS - 1);
      default:   return CNT_W'(BUS_CLKS - 1);
    endcase
  endfunction

  // Builds the ordered slot list for one instruction.
  function automatic plan_t buildPlan(logic isLong, logic [DK_W-1:0] dk);
    plan_t p;
    logic [IDX_W-1:0] n;
    p = '0;
    n = '0;
    if (dk[DK_W-1]) begin
      // Status/condition register: refetch after the mode settles.
      p.slots[n] = '{SK_PROG,   1'b0}; n = n + 1'b1;
      p.slots[n] = '{SK_IDLE_F, 1'b0}; n = n + 1'b1;
      p.slots[n] = '{SK_IDLE_F, 1'b0}; n = n + 1'b1;
      p.slots[n] = '{SK_PROG,   1'b0}; n = n + 1'b1;
      p.slots[n] = '{SK_PROG,   1'b0}; n = n + 1'b1;
    end else if (dk == DK_DREG) begin
      p.slots[n] = '{SK_PROG, 1'b0}; n = n + 1'b1;
      p.slots[n] = '{SK_PROG, 1'b0}; n = n + 1'b1;
      if (isLong) begin
        p.slots[n] = '{SK_PROG,   1'b0}; n = n + 1'b1;
        p.slots[n] = '{SK_IDLE_F, 1'b0}; n = n + 1'b1;
      end
    end else begin
      p.slots[n] = '{SK_PROG, 1'b0}; n = n + 1'b1;
      if (isLong) begin
        p.slots[n] = '{SK_PROG, 1'b0}; n = n + 1'b1;
      end
      if (dk == DK_PREDEC || dk == DK_INDEX) begin
        p.slots[n] = '{SK_IDLE_S, 1'b0}; n = n + 1'b1;
      end
      if (dk == DK_DISP || dk == DK_INDEX || dk == DK_ABSW || dk == DK_ABSL) begin
        p.slots[n] = '{SK_PROG, 1'b0}; n = n + 1'b1;
      end
      if (dk == DK_ABSL) begin
        p.slots[n] = '{SK_PROG, 1'b0}; n = n + 1'b1;
      end
      if (isLong) begin
        p.slots[n] = '{SK_DRD, 1'b1}; n = n + 1'b1;
        p.slots[n] = '{SK_DRD, 1'b0}; n = n + 1'b1;
        p.slots[n] = '{SK_PROG, 1'b0}; n = n + 1'b1;
        p.slots[n] = '{SK_DWR, 1'b0}; n = n + 1'b1;
        p.slots[n] = '{SK_DWR, 1'b1}; n = n + 1'b1;
      end else begin
        p.slots[n] = '{SK_DRD, 1'b0}; n = n + 1'b1;
        p.slots[n] = '{SK_PROG, 1'b0}; n = n + 1'b1;
        p.slots[n] = '{SK_DWR, 1'b0}; n = n + 1'b1;
      end
    end
    p.len = n;
    return p;
  endfunction

endpackage

// File: rtl/immSeqTimer.sv
module immSeqTimer
  import immSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  output logic [CNT_W-1:0] cnt,
  output logic [IDX_W-1:0] idx
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      idx <= '0;
    end else begin
      if (strobe.clrCnt)      cnt <= '0;
      else if (strobe.incCnt) cnt <= cnt + 1'b1;
      if (strobe.clrIdx)      idx <= '0;
      else if (strobe.incIdx) idx <= idx + 1'b1;
    end
  end

  AST_CNT_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrCnt, strobe.incCnt})); // R9
  AST_IDX_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrIdx, strobe.incIdx})); // R5

endmodule

// File: rtl/immSeqCtrl.sv
module immSeqCtrl
  import immSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             sizeLong,
  input  logic [DK_W-1:0]  destKind,
  input  logic             busReady,
  input  logic [CNT_W-1:0] cnt,
  input  logic [IDX_W-1:0] idx,
  output seqStrobe_t       strobe,
  output logic [2:0]       slotKind,
  output logic             hiWord,
  output logic             done
);

  seqState_e        state, stateNxt;
  plan_t            planQ;
  slot_t            curSlot;
  logic [CNT_W-1:0] lastCnt;
  logic             atLast, curIsBus, slotEnd, finalSlot;

  assign curSlot   = (idx < IDX_W'(MAX_SLOTS)) ? planQ.slots[idx] : '0;
  assign curIsBus  = isBusSlot(curSlot.kind);
  assign lastCnt   = slotLastCnt(curSlot.kind);
  assign atLast    = (cnt == lastCnt);
  assign slotEnd   = (state == ST_RUN) && atLast && (!curIsBus || busReady);
  assign finalSlot = (idx == planQ.len - 1'b1);

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    case (state)
      ST_IDLE: if (start) begin
        stateNxt      = ST_RUN;
        strobe.clrIdx = 1'b1;
        strobe.clrCnt = 1'b1;
      end
      ST_RUN: begin
        if (slotEnd) begin
          if (finalSlot) stateNxt = ST_DONE;
          else begin
            strobe.incIdx = 1'b1;
            strobe.clrCnt = 1'b1;
          end
        end else if (!atLast) begin
          strobe.incCnt = 1'b1;
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      planQ <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && start) planQ <= buildPlan(sizeLong, destKind);
    end
  end

  assign slotKind = (state == ST_RUN) ? curSlot.kind : SK_NONE;
  assign hiWord   = (state == ST_RUN) && curSlot.hi;
  assign done     = (state == ST_DONE);

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && curIsBus && atLast && !busReady)
      |=> (state == ST_RUN && $stable(idx) && $stable(cnt))); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (cnt <= lastCnt)); // R9
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !curIsBus && atLast)
      |=> (cnt == '0 || state == ST_DONE)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && start) |=> $stable(planQ)); // R12
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (idx < planQ.len)); // R2

endmodule

// File: rtl/immSlotSequencer.sv
module immSlotSequencer
  import immSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        sizeLong,
  input  logic [3:0]  destKind,
  input  logic        busReady,
  output logic [2:0]  slotKind,
  output logic        hiWord,
  output logic        done
);

  seqStrobe_t       strobe;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;

  immSeqCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .sizeLong (sizeLong),
    .destKind (destKind),
    .busReady (busReady),
    .cnt      (cnt),
    .idx      (idx),
    .strobe   (strobe),
    .slotKind (slotKind),
    .hiWord   (hiWord),
    .done     (done)
  );

  immSeqTimer uTimer (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cnt    (cnt),
    .idx    (idx)
  );

endmodule

// File: tb/immSlotSequencer_test.sv
`timescale 1ns/1ps
module immSlotSequencer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       sizeLong = 1'b0;
  logic [3:0] destKind = 4'd0;
  logic       busReady = 1'b1;
  logic [2:0] slotKind;
  logic       hiWord;
  logic       done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  immSlotSequencer uut (
    .clk(clk), .rstN(rstN), .start(start), .sizeLong(sizeLong),
    .destKind(destKind), .busReady(busReady),
    .slotKind(slotKind), .hiWord(hiWord), .done(done)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Reference slot lists from the ordering rules.
  task automatic refPlan(bit lng, int dk, ref int kq[$], ref int hq[$]);
    kq.delete(); hq.delete();
    if (dk >= 8) kq = '{1, 5, 5, 1, 1};
    else if (dk == 0) begin
      if (lng) kq = '{1, 1, 1, 5}; else kq = '{1, 1};
    end else begin
      kq.push_back(1);
      if (lng) kq.push_back(1);
      case (dk)
        3: kq.push_back(4);
        4, 6: kq.push_back(1);
        5: begin kq.push_back(4); kq.push_back(1); end
        7: begin kq.push_back(1); kq.push_back(1); end
        default: ;
      endcase
    end
    for (int i = 0; i < kq.size(); i++) hq.push_back(0);
    if (dk >= 1 && dk <= 7) begin
      if (lng) begin
        kq.push_back(2); hq.push_back(1);
        kq.push_back(2); hq.push_back(0);
        kq.push_back(1); hq.push_back(0);
        kq.push_back(3); hq.push_back(0);
        kq.push_back(3); hq.push_back(1);
      end else begin
        kq.push_back(2); hq.push_back(0);
        kq.push_back(1); hq.push_back(0);
        kq.push_back(3); hq.push_back(0);
      end
    end
  endtask

  function automatic int lenOf(int k);
    return (k == 4) ? 2 : 4;
  endfunction

  task automatic runSeq(bit lng, int dk, int expTotal, string tag,
                        int stallSlot, int stallCycles, bit lowOnIdle, bit pokeStart);
    int kq[$];
    int hq[$];
    int cycles = 0;
    int stallLeft = stallCycles;
    refPlan(lng, dk, kq, hq);
    @(negedge clk);
    sizeLong = lng; destKind = 4'(dk); start = 1'b1; busReady = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < kq.size(); i++) begin
      int c = 0;
      forever begin
        bit isBus = (kq[i] <= 3);
        bit last  = (c == lenOf(kq[i]) - 1);
        bit stalled = 0;
        chk(slotKind == 3'(kq[i]), (i == 0 && c == 0) ? "R2" : tag,
            $sformatf("slotKind slot %0d clk %0d", i, c), slotKind, kq[i]);
        chk(hiWord == hq[i], "R7", $sformatf("hiWord slot %0d", i), hiWord, hq[i]);
        chk(done == 1'b0, "R11", "done early", done, 0);
        if (pokeStart && i == 1 && c == 0) begin
          start = 1'b1; destKind = 4'd8; sizeLong = ~lng;   // R12
        end else start = 1'b0;
        if (isBus && last && i == stallSlot && stallLeft > 0) begin
          busReady = 1'b0; stallLeft--; stalled = 1;       // R9
        end else if (!isBus && lowOnIdle) busReady = 1'b0; // R10
        else busReady = 1'b1;
        cycles++;
        @(negedge clk);
        if (last && !stalled) break;
        if (!last) c++;
      end
    end
    start = 1'b0; busReady = 1'b1;
    chk(done == 1'b1, "R11", "done pulse", done, 1);
    chk(slotKind == 3'd0, "R11", "slotKind in done clock", slotKind, 0);
    chk(cycles == expTotal, tag, "active clocks", cycles, expTotal);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done width", done, 0);
    chk(slotKind == 3'd0, pokeStart ? "R12" : "R11", "idle after done", slotKind, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish();
  end

  initial begin
    int totW[8] = '{8, 16, 16, 18, 20, 22, 20, 24};
    int totL[8] = '{16, 28, 28, 30, 32, 34, 32, 36};
    repeat (3) @(negedge clk);
    chk(slotKind == 3'd0, "R1", "reset slotKind", slotKind, 0);
    chk(hiWord == 1'b0, "R1", "reset hiWord", hiWord, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(slotKind == 3'd0, "R1", "idle without start", slotKind, 0);

    runSeq(0, 0, totW[0], "R3", -1, 0, 0, 0);
    runSeq(1, 0, totL[0], "R4", -1, 0, 0, 0);
    for (int dk = 1; dk <= 7; dk++) begin
      runSeq(0, dk, totW[dk], (dk <= 2) ? "R5" : "R6", -1, 0, 0, 0);
      runSeq(1, dk, totL[dk], (dk <= 2) ? "R7" : "R6", -1, 0, 0, 0);
    end
    runSeq(0, 8, 20, "R8", -1, 0, 0, 0);
    runSeq(1, 15, 20, "R8", -1, 0, 0, 0);
    runSeq(0, 0, 8 + 3, "R9", 0, 3, 0, 0);
    runSeq(1, 1, 28 + 2, "R9", 2, 2, 0, 0);
    runSeq(1, 7, 36 + 1, "R9", 8, 1, 0, 0);
    runSeq(0, 12, 20, "R10", -1, 0, 1, 0);
    runSeq(0, 5, 22, "R10", -1, 0, 1, 0);
    runSeq(1, 0, 16, "R10", -1, 0, 1, 0);
    runSeq(0, 4, 20, "R12", -1, 0, 0, 1);
    runSeq(1, 3, 30, "R12", -1, 0, 0, 1);
    finish();
  end

endmodule